// File: doc/BRIEF.md
# Register Shift and Rotate Execution Unit

This unit performs the shift group of a 32-bit load/store core's register instructions. From a 6-bit function code it picks one of four operations on the rt operand: logical left, logical right, arithmetic right (sign filling) or rotate right. The shift amount comes either from the 5-bit immediate field or, in the variable forms, from the low five bits of the rs operand. Logical right and rotate right share a function code. A select bit chooses between them. That bit is a separate input for each form: instruction bit 21 for the immediate form and bit 6 for the variable form.

The amount is decoded once. A logarithmic stage network then applies it, so no stage ever shifts by the full word width. Function codes outside the group raise an illegal flag and force a zero result. The result and the flag are captured in a single output register, so every answer appears one clock after its inputs.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `o_result` becomes 0 and `o_illegal` becomes 0, whatever the other inputs are.
- R2: Function code 0x00 gives `i_rt` shifted left by `i_shamt`, with zeros filled in from the right.
- R3: Function code 0x02 gives `i_rt` shifted right logically by `i_shamt` when `i_rot_imm` is 0. It gives `i_rt` rotated right by `i_shamt` when `i_rot_imm` is 1. `i_rot_var` has no effect on this code.
- R4: Function code 0x03 gives `i_rt` shifted right by `i_shamt`, with copies of `i_rt[31]` filled in from the left.
- R5: Function code 0x04 gives `i_rt` shifted left by `i_rs[4:0]`.
- R6: Function code 0x06 gives `i_rt` shifted right logically by `i_rs[4:0]` when `i_rot_var` is 0. It gives `i_rt` rotated right by `i_rs[4:0]` when `i_rot_var` is 1. `i_rot_imm` has no effect on this code.
- R7: Function code 0x07 gives `i_rt` shifted right arithmetically by `i_rs[4:0]`.
- R8: The variable forms (0x04, 0x06, 0x07) ignore `i_rs[31:5]` and `i_shamt`. The immediate forms (0x00, 0x02, 0x03) ignore `i_rs` entirely.
- R9: A shift or rotate amount of zero returns `i_rt` unchanged, for every legal code.
- R10: Codes 0x01 and 0x05, and every code above 0x07, set `o_illegal` to 1 and `o_result` to 0. Legal codes set `o_illegal` to 0.
- R11: The outputs change only at a rising clock edge. They reflect the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_func | input | 6 | Function code |
| i_shamt | input | 5 | Immediate shift amount |
| i_rs | input | 32 | rs operand; low 5 bits give the variable amount |
| i_rt | input | 32 | Operand being shifted |
| i_rot_imm | input | 1 | Rotate select for code 0x02 (instruction bit 21) |
| i_rot_var | input | 1 | Rotate select for code 0x06 (instruction bit 6) |
| o_result | output | 32 | Registered result |
| o_illegal | output | 1 | Registered illegal-function flag |

## Verification
The assertions assume that every input is held steady and known at each rising edge while reset is low. They check outputs only against inputs captured at an edge when reset was already low. The bench changes inputs only on the falling edge. It holds known values, including through reset, so the captured inputs are always defined. Random codes cover the whole 6-bit space so that illegal codes occur. Random amounts include forced zero and 31 cases, and the bits of rs above the amount field are always random.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRAV = 6'h07;

  typedef enum logic [1:0] {
    OP_SLL = 2'd0,
    OP_SRL = 2'd1,
    OP_SRA = 2'd2,
    OP_ROR = 2'd3
  } shift_op_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [AMT_W-1:0]  reg_amt,
  input  logic              rot_imm,
  input  logic              rot_var,
  output shift_op_e         op,
  output logic [AMT_W-1:0]  amt,
  output logic              illegal
);
  logic use_reg;

  always_comb begin
    op      = OP_SLL;
    use_reg = 1'b0;
    illegal = 1'b0;
    unique case (func)
      FN_SLL:  op = OP_SLL;
      FN_SRL:  op = rot_imm ? OP_ROR : OP_SRL;
      FN_SRA:  op = OP_SRA;
      FN_SLLV: begin op = OP_SLL; use_reg = 1'b1; end
      FN_SRLV: begin op = rot_var ? OP_ROR : OP_SRL; use_reg = 1'b1; end
      FN_SRAV: begin op = OP_SRA; use_reg = 1'b1; end
      default: illegal = 1'b1;
    endcase
    amt = use_reg ? reg_amt : imm_amt;
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  shift_op_e         op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic              fill;

  assign fill     = (op == OP_SRA) ? din[DATA_W-1] : 1'b0;
  assign stage[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] moved;
    always_comb begin
      unique case (op)
        OP_SLL:  moved = {stage[k][DATA_W-S-1:0], {S{1'b0}}};
        OP_ROR:  moved = {stage[k][S-1:0], stage[k][DATA_W-1:S]};
        default: moved = {{S{fill}}, stage[k][DATA_W-1:S]};
      endcase
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        i_func,
  input  logic [4:0]        i_shamt,
  input  logic [31:0]       i_rs,
  input  logic [31:0]       i_rt,
  input  logic              i_rot_imm,
  input  logic              i_rot_var,
  output logic [31:0]       o_result,
  output logic              o_illegal
);
  localparam int AMT_W = $clog2(DATA_W);

  shift_op_e         w_op;
  logic [AMT_W-1:0]  w_amt;
  logic              w_illegal;
  logic [DATA_W-1:0] w_shifted;

  shift_decode #(.AMT_W(AMT_W)) u_dec (
    .func    (i_func),
    .imm_amt (i_shamt[AMT_W-1:0]),
    .reg_amt (i_rs[AMT_W-1:0]),
    .rot_imm (i_rot_imm),
    .rot_var (i_rot_var),
    .op      (w_op),
    .amt     (w_amt),
    .illegal (w_illegal)
  );

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .op   (w_op),
    .amt  (w_amt),
    .din  (i_rt[DATA_W-1:0]),
    .dout (w_shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_result  <= '0;
      o_illegal <= 1'b0;
    end else begin
      o_result  <= w_illegal ? '0 : w_shifted;
      o_illegal <= w_illegal;
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    o_illegal |-> (o_result == '0)); // R10

  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !o_illegal && $past(w_amt) == '0) |-> (o_result == $past(i_rt))); // R9

  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(i_func) == FN_SRA || $past(i_func) == FN_SRAV))
      |-> (o_result[31] == $past(i_rt[31]))); // R4

  AST_ROT_POP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !o_illegal && $past(w_op) == OP_ROR)
      |-> ($countones(o_result) == $countones($past(i_rt)))); // R3

  AST_SLL_LSB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !o_illegal && $past(w_op) == OP_SLL && $past(w_amt) != '0)
      |-> (o_result[0] == 1'b0)); // R2
endmodule

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  i_func = 6'h00;
  logic [4:0]  i_shamt = 5'd0;
  logic [31:0] i_rs = '0;
  logic [31:0] i_rt = '0;
  logic        i_rot_imm = 1'b0;
  logic        i_rot_var = 1'b0;
  logic [31:0] o_result;
  logic        o_illegal;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  shift_unit u0 (
    .clk(clk), .rst(rst), .i_func(i_func), .i_shamt(i_shamt),
    .i_rs(i_rs), .i_rt(i_rt), .i_rot_imm(i_rot_imm), .i_rot_var(i_rot_var),
    .o_result(o_result), .o_illegal(o_illegal)
  );

  function automatic logic [32:0] model(input logic [5:0] f, input logic [4:0] sa,
                                        input logic [31:0] rs, input logic [31:0] rt,
                                        input logic ri, input logic rv);
    logic [4:0] n;
    logic       rot;
    n   = (f >= 6'h04) ? rs[4:0] : sa;
    rot = (f == 6'h02) ? ri : rv;
    case (f)
      6'h00, 6'h04: return {1'b0, rt << n};
      6'h02, 6'h06: begin
        if (!rot)       return {1'b0, rt >> n};
        else if (n == 0) return {1'b0, rt};
        else            return {1'b0, (rt >> n) | (rt << (6'd32 - {1'b0, n}))};
      end
      6'h03, 6'h07: return {1'b0, 32'($signed(rt) >>> n)};
      default:      return {1'b1, 32'h0};
    endcase
  endfunction

  function automatic string tag(input logic [5:0] f);
    case (f)
      6'h00: return "R2";
      6'h02: return "R3";
      6'h03: return "R4";
      6'h04: return "R5";
      6'h06: return "R6";
      6'h07: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got illegal=%0b result=%h, expected illegal=%0b result=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [5:0] f, input logic [4:0] sa, input logic [31:0] rs,
                       input logic [31:0] rt, input logic ri, input logic rv, input string req);
    @(negedge clk);
    i_func = f; i_shamt = sa; i_rs = rs; i_rt = rt; i_rot_imm = ri; i_rot_var = rv;
    @(posedge clk);
    #1;
    check(req, {o_illegal, o_result}, model(f, sa, rs, rt, ri, rv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    i_func = 6'h02; i_shamt = 5'd3; i_rt = 32'hFFFF_0000;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {o_illegal, o_result}, 33'h0);
    @(negedge clk);
    i_func = 6'h3F;
    @(posedge clk);
    #1;
    check("R1", {o_illegal, o_result}, 33'h0);
    @(negedge clk);
    rst = 1'b0;

    apply(6'h00, 5'd4,  32'hFFFF_FFFF, 32'h8000_000F, 1'b1, 1'b1, "R2");
    apply(6'h00, 5'd31, 32'h0,         32'h0000_0003, 1'b0, 1'b0, "R2");
    apply(6'h02, 5'd8,  32'h0,         32'h8123_4567, 1'b0, 1'b1, "R3");
    apply(6'h02, 5'd8,  32'h0,         32'h8123_4567, 1'b1, 1'b0, "R3");
    apply(6'h02, 5'd31, 32'h0,         32'h0000_0001, 1'b1, 1'b0, "R3");
    apply(6'h03, 5'd4,  32'h0,         32'h8000_0000, 1'b0, 1'b0, "R4");
    apply(6'h03, 5'd31, 32'h0,         32'h7FFF_FFFF, 1'b0, 1'b0, "R4");
    apply(6'h04, 5'd9,  32'hFFFF_FFE3, 32'h0000_0001, 1'b0, 1'b0, "R5 R8");
    apply(6'h06, 5'd0,  32'h1234_5670 | 32'h4, 32'hF000_0000, 1'b1, 1'b0, "R6");
    apply(6'h06, 5'd7,  32'hABCD_EF04, 32'h0000_000F, 1'b0, 1'b1, "R6 R8");
    apply(6'h07, 5'd2,  32'hFFFF_FFF0 | 32'h8, 32'hF000_0000, 1'b0, 1'b0, "R7 R8");
    apply(6'h02, 5'd0,  32'h0,         32'hDEAD_BEEF, 1'b1, 1'b0, "R9");
    apply(6'h06, 5'd5,  32'hFFFF_FFE0, 32'hDEAD_BEEF, 1'b0, 1'b1, "R9");
    apply(6'h03, 5'd0,  32'h0,         32'h8000_0001, 1'b0, 1'b0, "R9");
    apply(6'h01, 5'd1,  32'h1,         32'hFFFF_FFFF, 1'b0, 1'b0, "R10");
    apply(6'h05, 5'd1,  32'h1,         32'hFFFF_FFFF, 1'b0, 1'b0, "R10");
    apply(6'h08, 5'd1,  32'h1,         32'hFFFF_FFFF, 1'b0, 1'b0, "R10");
    apply(6'h00, 5'd0,  32'h0,         32'h0,         1'b0, 1'b0, "R2");

    // R11: new inputs are not visible before the next rising edge
    @(negedge clk);
    i_func = 6'h00; i_shamt = 5'd1; i_rt = 32'h1; i_rs = '0;
    #2;
    check("R11", {o_illegal, o_result}, 33'h0);
    @(posedge clk);
    #1;
    check("R11", {o_illegal, o_result}, 33'h2);

    for (int i = 0; i < 400; i++) begin
      logic [5:0]  f;
      logic [4:0]  sa;
      logic [31:0] rs;
      logic [31:0] rt;
      int          pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: f = 6'h00; 1: f = 6'h02; 2: f = 6'h03;
        3: f = 6'h04; 4: f = 6'h06; 5: f = 6'h07;
        6: f = 6'h02; 7: f = 6'h06;
        default: f = 6'($urandom);
      endcase
      sa = 5'($urandom);
      rs = $urandom;
      rt = $urandom;
      if ((i % 17) == 0) begin sa = 5'd0; rs[4:0] = 5'd0; end
      if ((i % 23) == 0) begin sa = 5'd31; rs[4:0] = 5'd31; end
      apply(f, sa, rs, rt, 1'($urandom), 1'($urandom), tag(f));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule